// File: doc/BRIEF.md
# Command-Queue SPI Master

This block is a serial peripheral interface master that works through a short list of command entries held in on-block storage. Each entry names a chip-select pattern and may ask for a transfer length other than the 8-bit default. Each entry also owns one transmit word and one receive word. Software loads the entries and data through a synchronous register port. It then writes a start and an end pointer together with a go bit. The engine runs every entry from start to end, wrapping past the last slot. Received words land in the matching receive slots.

All four clock polarity/phase combinations are supported. Data moves most significant bit first. The SCK half period is a programmable number of system clocks. While the queue is not running, the serial clock, data-out and chip-select pins are driven from a port data register instead of the engine. A low level on the slave-select input while master mode is on is a mode fault. A fault halts the queue at once, drops master mode and sets a sticky flag. An open-drain option turns every output into a drive-low-only pin.

Top module: `spi_cmd_queue`

## Requirements
- R1: After reset, the control and status registers read 0, every output enable is 1, and the pins show the port register's reset value: SCK 0, MOSI 0, chip-selects 4'hF.
- R2: Control word at address 0 holds master bit0, CPOL bit1, CPHA bit2, open-drain bit3, length field bits[7:4] and baud bits[15:8]. SCK rests at CPOL, and the first edge of every transfer moves away from CPOL. With CPHA=0 MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1 MOSI changes on leading edges and MISO is sampled on trailing edges.
- R3: MOSI sends the entry's transmit word, starting at bit n-1 of an n-bit transfer and ending at bit 0.
- R4: The received bits go into the entry's receive word, right-justified (first bit received at bit n-1), upper bits 0. Receive slot i is read at address 0x30+i.
- R5: A command entry (address 0x10+i, bits[3:0] active-low chip-selects, bit4 length-enable) transfers 8 bits when length-enable is 0. When it is 1, the length field sets the size: 0 means 16, 1 to 7 mean 8, and 8 to 15 mean themselves.
- R6: Each SCK half period lasts exactly baud system clocks. A baud value of 0 produces no SCK edge and the queue does not advance.
- R7: A write to address 1 with bit15 set starts the queue from the start pointer (bits[1:0]) to the end pointer (bits[9:8]), wrapping from the last slot to 0. Status bits[9:8] show the current entry index.
- R8: Status (address 2) bit0 is a sticky completion flag set after each command, and bit2 is busy while the queue runs. Writing 1 to bit0 clears the completion flag.
- R9: While the queue runs, the chip-select pins carry the current entry's pattern.
- R10: While the queue is idle, SCK, MOSI and chip-selects follow the port register at address 3 (bit0 SCK, bit1 MOSI, bits[5:2] chip-selects).
- R11: A low slave-select input while master mode is on stops the queue at once, clears the master bit, returns the pins to port control and sets status bit1. Writing 1 to status bit1 clears it.
- R12: With open-drain enabled, each output's enable is the inverse of its value, whether the queue runs or not. Otherwise every enable is 1.
- R13: A go request while master mode is off is ignored: busy stays 0 and the pins stay on port control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears on reg_rdata after the next edge |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| sck_o | output | 1 | Serial clock pin value |
| sck_oe | output | 1 | Serial clock pin drive enable |
| mosi_o | output | 1 | Serial data-out pin value |
| mosi_oe | output | 1 | Serial data-out drive enable |
| miso_i | input | 1 | Serial data-in |
| cs_n_o | output | 4 | Active-low chip-select pin values |
| cs_oe | output | 4 | Chip-select drive enables |
| ss_n_i | input | 1 | Active-low slave-select input used for fault detection |

## Verification
The assertions assume that slave-select and MISO are already synchronous to the system clock. They also assume that command and control contents are not rewritten while the queue runs, so that the chip-select pattern may be taken as stable within one entry. The bench drives MISO and slave-select only on falling clock edges, from a reactive slave model. It writes command, data and control registers only while busy is low, and it sets the port SCK bit equal to CPOL before each run, so no false edge appears at hand-over.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int DATA_W  = 16;
    localparam int LEN_W   = 4;
    localparam int CS_W    = 4;
    localparam int BAUD_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int NBITS_W = 5;
    localparam int DEF_LEN = 8;

    typedef struct packed {
        logic [BAUD_W-1:0] baud;
        logic [LEN_W-1:0]  len;
        logic              od;
        logic              cpha;
        logic              cpol;
        logic              master;
    } ctrl_t;

    typedef struct packed {
        logic            len_en;
        logic [CS_W-1:0] cs_n;
    } cmd_t;

    typedef struct packed {
        logic [CS_W-1:0] cs_n;
        logic            mosi;
        logic            sck;
    } pins_t;

    localparam int CMD_W  = $bits(cmd_t);
    localparam int PINS_W = $bits(pins_t);

    localparam logic [3:0] REG_CTRL  = 4'd0;
    localparam logic [3:0] REG_QUEUE = 4'd1;
    localparam logic [3:0] REG_STAT  = 4'd2;
    localparam logic [3:0] REG_PORT  = 4'd3;

    localparam logic [1:0] RGN_REGS = 2'd0;
    localparam logic [1:0] RGN_CMD  = 2'd1;
    localparam logic [1:0] RGN_TX   = 2'd2;
    localparam logic [1:0] RGN_RX   = 2'd3;

    localparam int GO_BIT     = 15;
    localparam int END_LSB    = 8;
    localparam int ST_DONE    = 0;
    localparam int ST_FAULT   = 1;
    localparam int ST_BUSY    = 2;
    localparam int ST_IDX_LSB = 8;

    localparam pins_t PORT_RST = '{cs_n: '1, mosi: 1'b0, sck: 1'b0};

    function automatic logic [NBITS_W-1:0] xfer_len(input logic en,
                                                    input logic [LEN_W-1:0] fld);
        if (!en)
            return NBITS_W'(DEF_LEN);
        else if (fld == '0)
            return NBITS_W'(DATA_W);
        else if (fld < LEN_W'(DEF_LEN))
            return NBITS_W'(DEF_LEN);
        else
            return NBITS_W'(fld);
    endfunction
endpackage

// File: rtl/sq_baud.sv
module sq_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             at_top;

    assign at_top = (cnt == div - DIV_W'(1));
    assign tick   = en && (div != '0) && at_top;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (div != '0)
            cnt <= at_top ? '0 : cnt + DIV_W'(1);
    end

    assert_no_tick_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |-> !tick);

    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && div > DIV_W'(1) && en) |=> !tick);
endmodule

// File: rtl/sq_shifter.sv
module sq_shifter
    import sq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               abort,
    input  logic               tick,
    input  logic               cpol,
    input  logic               cpha,
    input  logic [NBITS_W-1:0] len,
    input  logic [DATA_W-1:0]  tx,
    input  logic               miso,
    output logic               active,
    output logic               sck,
    output logic               mosi,
    output logic               done,
    output logic [DATA_W-1:0]  rx
);
    logic [NBITS_W:0]   edges;
    logic [NBITS_W-1:0] nbits;
    logic [DATA_W-1:0]  shreg;
    logic               lead;
    logic               last;
    logic [3:0]         msb_idx;

    assign lead    = ~edges[0];
    assign last    = (edges + (NBITS_W+1)'(1)) == {nbits, 1'b0};
    assign msb_idx = 4'(nbits - NBITS_W'(1));
    assign mosi    = shreg[msb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            edges  <= '0;
            nbits  <= NBITS_W'(DEF_LEN);
            shreg  <= '0;
            rx     <= '0;
            sck    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                sck    <= cpol;
            end else if (start && !active) begin
                active <= 1'b1;
                edges  <= '0;
                nbits  <= len;
                shreg  <= tx;
                rx     <= '0;
                sck    <= cpol;
            end else if (active && tick) begin
                edges <= edges + (NBITS_W+1)'(1);
                sck   <= ~sck;
                if (lead) begin
                    if (!cpha)
                        rx <= {rx[DATA_W-2:0], miso};
                    else if (edges != '0)
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                end else begin
                    if (cpha)
                        rx <= {rx[DATA_W-2:0], miso};
                    else if (!last)
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                end
                if (last) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end else if (!active) begin
                sck <= cpol;
            end
        end
    end

    assert_sck_rests_R2: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active) && $stable(cpol)) |-> (sck == cpol));

    assert_edge_bound_R5: assert property (@(posedge clk) disable iff (rst)
        active |-> (edges < {nbits, 1'b0}));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && sck == cpol));
endmodule

// File: rtl/sq_qram.sv
module sq_qram
    import sq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              tx_we,
    input  logic [IW-1:0]     bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rx_we,
    input  logic [IW-1:0]     eng_idx,
    input  logic [DATA_W-1:0] rx_wdata,
    output cmd_t              eng_cmd,
    output logic [DATA_W-1:0] eng_tx,
    output cmd_t              bus_cmd,
    output logic [DATA_W-1:0] bus_tx,
    output logic [DATA_W-1:0] bus_rx
);
    cmd_t              cmd_q [DEPTH];
    logic [DATA_W-1:0] tx_q  [DEPTH];
    logic [DATA_W-1:0] rx_q  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cmd_q[i] <= '{len_en: 1'b0, cs_n: '1};
                tx_q[i]  <= '0;
                rx_q[i]  <= '0;
            end else begin
                if (cmd_we && bus_idx == IW'(i))
                    cmd_q[i] <= cmd_t'(bus_wdata[CMD_W-1:0]);
                if (tx_we && bus_idx == IW'(i))
                    tx_q[i] <= bus_wdata;
                if (rx_we && eng_idx == IW'(i))
                    rx_q[i] <= rx_wdata;
            end
        end
    end

    assign eng_cmd = cmd_q[eng_idx];
    assign eng_tx  = tx_q[eng_idx];
    assign bus_cmd = cmd_q[bus_idx];
    assign bus_tx  = tx_q[bus_idx];
    assign bus_rx  = rx_q[bus_idx];
endmodule

// File: rtl/spi_cmd_queue.sv
module spi_cmd_queue
    import sq_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic [CS_W-1:0]   cs_n_o,
    output logic [CS_W-1:0]   cs_oe,
    input  logic              ss_n_i
);
    localparam int PW = $clog2(QDEPTH);

    ctrl_t             ctrl;
    pins_t             port;
    pins_t             drive;
    logic [PW-1:0]     sptr, eptr, idx;
    logic              run, launch, done_f, fault_f;
    logic              fault_now, go;
    logic              wr_regs, wr_ctrl, wr_queue, wr_stat, wr_port;
    cmd_t              eng_cmd, bus_cmd;
    logic [DATA_W-1:0] eng_tx, bus_tx, bus_rx, sh_rx, rd_mux;
    logic              sh_active, sh_sck, sh_mosi, sh_done, tick;

    assign wr_regs   = reg_we && reg_addr[5:4] == RGN_REGS;
    assign wr_ctrl   = wr_regs && reg_addr[3:0] == REG_CTRL;
    assign wr_queue  = wr_regs && reg_addr[3:0] == REG_QUEUE;
    assign wr_stat   = wr_regs && reg_addr[3:0] == REG_STAT;
    assign wr_port   = wr_regs && reg_addr[3:0] == REG_PORT;
    assign fault_now = ctrl.master && !ss_n_i;
    assign go        = wr_queue && reg_wdata[GO_BIT] && ctrl.master && !run && !fault_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            port    <= PORT_RST;
            sptr    <= '0;
            eptr    <= '0;
            idx     <= '0;
            run     <= 1'b0;
            launch  <= 1'b0;
            done_f  <= 1'b0;
            fault_f <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (wr_ctrl)
                ctrl <= ctrl_t'(reg_wdata);
            if (wr_port)
                port <= pins_t'(reg_wdata[PINS_W-1:0]);
            if (wr_queue && !run) begin
                sptr <= reg_wdata[PW-1:0];
                eptr <= reg_wdata[END_LSB +: PW];
            end
            if (wr_stat && reg_wdata[ST_DONE])
                done_f <= 1'b0;
            if (wr_stat && reg_wdata[ST_FAULT])
                fault_f <= 1'b0;

            if (fault_now) begin
                ctrl.master <= 1'b0;
                fault_f     <= 1'b1;
                run         <= 1'b0;
            end else if (go) begin
                run    <= 1'b1;
                idx    <= reg_wdata[PW-1:0];
                launch <= 1'b1;
            end else if (run && sh_done) begin
                done_f <= 1'b1;
                if (idx == eptr) begin
                    run <= 1'b0;
                end else begin
                    idx    <= (idx == PW'(QDEPTH - 1)) ? '0 : idx + PW'(1);
                    launch <= 1'b1;
                end
            end
        end
    end

    sq_qram #(.DEPTH(QDEPTH), .IW(PW)) u_qram (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (reg_we && reg_addr[5:4] == RGN_CMD),
        .tx_we    (reg_we && reg_addr[5:4] == RGN_TX),
        .bus_idx  (reg_addr[PW-1:0]),
        .bus_wdata(reg_wdata),
        .rx_we    (run && sh_done),
        .eng_idx  (idx),
        .rx_wdata (sh_rx),
        .eng_cmd  (eng_cmd),
        .eng_tx   (eng_tx),
        .bus_cmd  (bus_cmd),
        .bus_tx   (bus_tx),
        .bus_rx   (bus_rx)
    );

    sq_baud #(.DIV_W(BAUD_W)) u_baud (
        .clk (clk),
        .rst (rst),
        .en  (sh_active),
        .div (ctrl.baud),
        .tick(tick)
    );

    sq_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (launch),
        .abort (fault_now),
        .tick  (tick),
        .cpol  (ctrl.cpol),
        .cpha  (ctrl.cpha),
        .len   (xfer_len(eng_cmd.len_en, ctrl.len)),
        .tx    (eng_tx),
        .miso  (miso_i),
        .active(sh_active),
        .sck   (sh_sck),
        .mosi  (sh_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    always_comb begin
        if (run)
            drive = '{cs_n: eng_cmd.cs_n, mosi: sh_mosi, sck: sh_sck};
        else
            drive = port;
    end

    assign sck_o   = drive.sck;
    assign mosi_o  = drive.mosi;
    assign cs_n_o  = drive.cs_n;
    assign sck_oe  = ctrl.od ? ~drive.sck  : 1'b1;
    assign mosi_oe = ctrl.od ? ~drive.mosi : 1'b1;
    assign cs_oe   = ctrl.od ? ~drive.cs_n : '1;

    always_comb begin
        rd_mux = '0;
        case (reg_addr[5:4])
            RGN_REGS: begin
                case (reg_addr[3:0])
                    REG_CTRL:  rd_mux = DATA_W'(ctrl);
                    REG_QUEUE: begin
                        rd_mux[PW-1:0]         = sptr;
                        rd_mux[END_LSB +: PW]  = eptr;
                    end
                    REG_STAT: begin
                        rd_mux[ST_DONE]          = done_f;
                        rd_mux[ST_FAULT]         = fault_f;
                        rd_mux[ST_BUSY]          = run;
                        rd_mux[ST_IDX_LSB +: PW] = idx;
                    end
                    REG_PORT:  rd_mux = DATA_W'(port);
                    default:   rd_mux = '0;
                endcase
            end
            RGN_CMD: rd_mux = DATA_W'(bus_cmd);
            RGN_TX:  rd_mux = bus_tx;
            default: rd_mux = bus_rx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_re)
            reg_rdata <= rd_mux;
    end

    assert_fault_stops_R11: assert property (@(posedge clk) disable iff (rst)
        (ctrl.master && !ss_n_i) |=> (!run && !ctrl.master && fault_f));

    assert_go_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.master && !run) |=> !run);

    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (rst)
        (run && sh_done && idx == eptr && !fault_now) |=> (!run && done_f));

    assert_cs_held_R9: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(idx) && !$past(reg_we)) |-> $stable(cs_n_o));

    assert_open_drain_R12: assert property (@(posedge clk) disable iff (rst)
        ctrl.od |-> (!(sck_oe && sck_o) && !(mosi_oe && mosi_o) && ((cs_oe & cs_n_o) == '0)));

    assert_idle_engine_R10: assert property (@(posedge clk) disable iff (rst)
        (!run && !launch) |=> !sh_active);
endmodule

// File: tb/tb_spi_cmd_queue.sv
`timescale 1ns/1ps
module tb_spi_cmd_queue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sck_o, sck_oe, mosi_o, mosi_oe;
    logic        miso_i = 1'b0;
    logic [3:0]  cs_n_o, cs_oe;
    logic        ss_n_i = 1'b1;

    always #2 clk = ~clk;

    spi_cmd_queue dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .cs_n_o(cs_n_o),
        .cs_oe(cs_oe), .ss_n_i(ss_n_i)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    function automatic int exp_len(input bit en, input int fld);
        if (!en) return 8;
        if (fld == 0) return 16;
        if (fld < 8) return 8;
        return fld;
    endfunction

    // reactive slave model
    bit          m_rst = 0, m_on = 0, m_cpol = 0, m_cpha = 0;
    int          m_baud = 1, m_cnt = 0;
    int          m_ord [4];
    int          m_len [4];
    logic [15:0] m_sw  [4];
    logic [15:0] m_tx  [4];
    logic [15:0] m_cap [4];
    logic [3:0]  m_cs  [4];
    int          e = 0, bp = 0, cur = 0, k = 0, n = 0;
    int          sp_err = 0, md_err = 0, cs_err = 0;
    logic [15:0] cap = '0;
    bit          psck = 0, lead = 0;
    longint      cyc = 0, lastc = 0;

    always @(negedge clk) begin
        cyc++;
        if (m_rst) begin
            e = 0; bp = 0; cur = 0; cap = '0;
            sp_err = 0; md_err = 0; cs_err = 0;
            miso_i = m_cpha ? 1'b0 : m_sw[m_ord[0]][m_len[m_ord[0]] - 1];
            m_rst = 0;
        end else if (m_on && sck_o !== psck && cur < m_cnt) begin
            k = m_ord[cur];
            n = m_len[k];
            lead = (sck_o != m_cpol);
            e++;
            if (e == 1 && !lead) md_err++;
            if (e > 1 && (cyc - lastc) != longint'(m_baud)) sp_err++;
            lastc = cyc;
            if (cs_n_o != m_cs[k]) cs_err++;
            if (!m_cpha) begin
                if (lead) cap = {cap[14:0], mosi_o};
                else begin
                    bp++;
                    if (bp < n) miso_i = m_sw[k][n - 1 - bp];
                end
            end else begin
                if (lead) begin
                    miso_i = m_sw[k][n - 1 - bp];
                    bp++;
                end else cap = {cap[14:0], mosi_o};
            end
            if (e == 2 * n) begin
                m_cap[k] = cap;
                cap = '0; e = 0; bp = 0; cur++;
                if (!m_cpha && cur < m_cnt)
                    miso_i = m_sw[m_ord[cur]][m_len[m_ord[cur]] - 1];
            end
        end
        psck = sck_o;
    end

    task automatic wait_idle(output bit ok);
        logic [15:0] s;
        ok = 0;
        for (int t = 0; t < 5000; t++) begin
            rd(6'h02, s);
            if (!s[2]) begin ok = 1; break; end
        end
    endtask

    task automatic run_queue(input int mode, input int baud, input int st, input int en, input int fld, input int rid);
        bit cpol, cpha, ok;
        logic [15:0] s, r, mask;
        cpol = mode[1];
        cpha = mode[0];
        wr(6'h03, {10'b0, 4'hF, 1'b0, cpol});
        for (int i = 0; i < 4; i++) begin
            bit len_en;
            len_en   = (i == 1 || i == 2);
            m_len[i] = exp_len(len_en, fld);
            m_tx[i]  = 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(rid * 16'h0F1E);
            m_sw[i]  = ~{m_tx[i][7:0], m_tx[i][15:8]} ^ 16'(rid * 3);
            m_cs[i]  = 4'hF ^ 4'(1 << i);
            m_cap[i] = '0;
            wr(6'h10 + 6'(i), {11'b0, len_en, m_cs[i]});
            wr(6'h20 + 6'(i), m_tx[i]);
        end
        wr(6'h00, {8'(baud), 4'(fld), 1'b0, cpha, cpol, 1'b1});
        wr(6'h02, 16'h0003);
        m_cnt = ((en - st + 4) % 4) + 1;
        for (int j = 0; j < 4; j++) m_ord[j] = (st + j) % 4;
        m_cpol = cpol; m_cpha = cpha; m_baud = baud;
        m_on = 1; m_rst = 1;
        @(negedge clk); @(negedge clk);
        wr(6'h01, 16'h8000 | 16'(en << 8) | 16'(st));
        wait_idle(ok);
        m_on = 0;
        chk(ok, "R7 queue finished", ok, 1);
        chk(cur == m_cnt, "R5 command count by length", cur, m_cnt);
        chk(md_err == 0, "R2 first edge leaves idle level", md_err, 0);
        chk(sp_err == 0, "R6 half period", sp_err, 0);
        chk(cs_err == 0, "R9 chip-select pattern", cs_err, 0);
        for (int j = 0; j < m_cnt; j++) begin
            int kk;
            kk = m_ord[j];
            mask = (m_len[kk] == 16) ? 16'hFFFF : 16'((1 << m_len[kk]) - 1);
            chk(m_cap[kk] == (m_tx[kk] & mask), "R3 MOSI word msb first", m_cap[kk], m_tx[kk] & mask);
            rd(6'h30 + 6'(kk), r);
            chk(r == (m_sw[kk] & mask), "R4 receive word", r, m_sw[kk] & mask);
        end
        rd(6'h02, s);
        chk(s[0] == 1'b1, "R8 completion flag", s[0], 1);
        chk(s[9:8] == 2'(en), "R7 status index", s[9:8], en);
        chk(sck_o == cpol && cs_n_o == 4'hF, "R10 pins back to port", {sck_o, cs_n_o}, {cpol, 4'hF});
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int chg;
        bit ok, last_sck;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(sck_o == 0 && mosi_o == 0 && cs_n_o == 4'hF, "R1 reset pins", {sck_o, mosi_o, cs_n_o}, 6'h0F);
        chk(sck_oe && mosi_oe && cs_oe == 4'hF, "R1 reset enables", {sck_oe, mosi_oe, cs_oe}, 6'h3F);
        rd(6'h00, d); chk(d == 0, "R1 control reset", d, 0);
        rd(6'h02, d); chk(d == 0, "R1 status reset", d, 0);

        // R10 idle pins from port register
        wr(6'h03, 16'h002B);
        chk(sck_o == 1 && mosi_o == 1 && cs_n_o == 4'b1010, "R10 port drive", {sck_o, mosi_o, cs_n_o}, 6'h3A);

        // R12 open drain
        wr(6'h00, 16'h0008);
        chk(!sck_oe && !mosi_oe && cs_oe == 4'b0101, "R12 open-drain enables", {sck_oe, mosi_oe, cs_oe}, 6'h05);
        wr(6'h00, 16'h0000);
        chk(sck_oe && mosi_oe && cs_oe == 4'hF, "R12 push-pull enables", {sck_oe, mosi_oe, cs_oe}, 6'h3F);

        // R13 go with master off
        wr(6'h01, 16'h8300);
        repeat (20) @(negedge clk);
        rd(6'h02, d);
        chk(d[2] == 0, "R13 go ignored busy", d[2], 0);
        chk(sck_o == 1 && cs_n_o == 4'b1010, "R13 pins unchanged", {sck_o, cs_n_o}, 5'h1A);

        // sweep of modes, rates and queue windows
        for (int m = 0; m < 4; m++) begin
            int flds [4] = '{0, 5, 11, 15};
            run_queue(m, 1, m, (m + 3) % 4, flds[m], 2 * m);
            run_queue(m, 3, (m + 1) % 4, (m + 2) % 4, flds[3 - m], 2 * m + 1);
        end
        run_queue(1, 2, 2, 2, 9, 9);

        // R8 clear completion flag
        wr(6'h02, 16'h0001);
        rd(6'h02, d);
        chk(d[0] == 0, "R8 completion flag clear", d[0], 0);

        // R6 baud zero stalls, then R11 fault
        wr(6'h03, 16'h003C);
        wr(6'h00, 16'h0001);
        wr(6'h01, 16'h8300);
        chg = 0;
        last_sck = sck_o;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (sck_o != last_sck) chg++;
            last_sck = sck_o;
        end
        chk(chg == 0, "R6 baud zero no edges", chg, 0);
        rd(6'h02, d);
        chk(d[2] == 1, "R6 baud zero queue stalls busy", d[2], 1);
        chk(cs_n_o == 4'hE, "R9 chip-select during stall", cs_n_o, 4'hE);
        @(negedge clk);
        ss_n_i = 1'b0;
        @(negedge clk);
        ss_n_i = 1'b1;
        chk(cs_n_o == 4'hF && sck_o == 0, "R11 pins to port on fault", {sck_o, cs_n_o}, 5'h0F);
        rd(6'h02, d);
        chk(d[2] == 0 && d[1] == 1, "R11 fault stops queue", d[2:0], 3'b010);
        rd(6'h00, d);
        chk(d[0] == 0, "R11 master bit cleared", d[0], 0);
        wr(6'h02, 16'h0002);
        rd(6'h02, d);
        chk(d[1] == 0, "R11 fault flag clear", d[1], 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule